// File: doc/BRIEF.md
# SD Command/Response Engine

This block sends one SD command at a time on a single command line and collects the card's answer. Software supplies a 6-bit command index, a 32-bit argument and a response kind, then pulses `start`. The engine builds the 48-bit frame around those fields. It adds the framing bits and the 7-bit checksum itself and shifts the frame out most significant bit first. It then releases the line, lets a fixed turnaround pass, and hunts for the card's start bit within a programmable number of card clocks.

Card clock edges arrive as one-cycle strobes (`card_fall`, `card_rise`) from an external divider. The line is driven after a falling-edge strobe and sampled on a rising-edge strobe. A received response is checked for its framing bits and its checksum. The outcome lands in a four-bit sticky status word: bit 0 marks a clean completion, bit 1 a response timeout, bit 2 a checksum mismatch and bit 3 a framing fault. Each status bit is cleared by writing one to it. A per-bit enable mask selects which bits raise the single interrupt output.

Top module: `sdcmd_engine`

## Requirements
- R1: Every command frame starts with a 0 start bit and a 1 direction bit and ends with a 1 stop bit; software supplies none of them.
- R2: Bits 2 to 7 of the frame carry the command index and bits 8 to 39 the argument, each most significant bit first; any index value 0 to 63 is sent as given.
- R3: Frame bits 40 to 46 carry the CRC7 (polynomial x^7+x^3+1, zero start value) of frame bits 0 to 39.
- R4: `cmd_oe` is high for exactly the 48 frame bits, and the line is released high at the next falling strobe after the stop bit.
- R5: With response kind 2'b00 the command ends when the line is released, setting status bit 0 and clearing `busy`.
- R6: The first TURN_CYC rising strobes after release are not sampled, so a low level on the line during them does not start a response.
- R7: If `tmo_lim` consecutive rising-strobe samples after the turnaround see no start bit (a limit of 0 acts as 1), status bit 1 is set and the engine goes idle.
- R8: Response kinds 2'b01 and 2'b11 receive 48 bits. Their CRC7 covers received bits 0 to 39, and the frame ends up in `rsp_bits[47:0]` with the upper bits zero. A clean response sets status bit 0.
- R9: Response kind 2'b10 receives 136 bits, and its CRC7 covers only received bits 8 to 127, that is `rsp_bits[127:8]`.
- R10: A received CRC7 field that differs from the computed one sets status bit 2 and not bit 0.
- R11: A received direction bit of 1 or a stop bit of 0 sets status bit 3 and not bit 0.
- R12: Status bits are sticky. A bit clears only when 1 is written to the same bit of `sts_clr`, and other bits are unaffected.
- R13: `irq` is the OR of `sts & irq_en`, following one clock later when IRQ_REG is 1.
- R14: A `start` pulse while `busy` is high is ignored and does not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_fall | input | 1 | One-cycle strobe at each card clock falling edge |
| card_rise | input | 1 | One-cycle strobe at each card clock rising edge |
| start | input | 1 | Begin a command (ignored while busy) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 00 none, 01/11 short, 10 long |
| tmo_lim | input | TMO_W | Response wait limit in card clocks |
| sts_clr | input | 4 | Write-one-to-clear pulse for status bits |
| irq_en | input | 4 | Interrupt enable per status bit |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input value |
| busy | output | 1 | A command or response is in progress |
| sts | output | 4 | Status: 0 done, 1 timeout, 2 CRC error, 3 framing error |
| irq | output | 1 | Merged interrupt request |
| rsp_bits | output | 136 | Received response frame, last bit in bit 0 |

## Verification
The bench builds the engine with TMO_W=6, TURN_CYC=2 and IRQ_REG=1. The narrow limit lets single-count timeout boundaries be hit in a few dozen card clocks. The two-strobe turnaround gives an exact window for a deliberate low pulse that must be ignored. The registered interrupt variant exercises the one-cycle mask-to-request path. Short and long responses use checksums from the bench's own divider, and known command frames are compared against fixed 48-bit constants.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
   localparam int CMD_BITS = 48;
   localparam int RSP_SHORT = 48;
   localparam int RSP_LONG = 136;
   localparam int CRC_W = 7;
   localparam int IDX_W = 6;
   localparam int ARG_W = 32;
   localparam int NSTS = 4;
   localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'b00,
      KIND_SHORT = 2'b01,
      KIND_LONG  = 2'b10,
      KIND_SHALT = 2'b11
   } rsp_kind_e;

   typedef struct packed {
      logic frm;
      logic crc;
      logic tmo;
      logic done;
   } evt_t;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
   parameter int W = 7,
   parameter logic [W-1:0] POLY = 7'h09
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         upd,
   input  logic         shl,
   input  logic         din,
   output logic [W-1:0] crc
);
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("sdcmd_crc7: polynomial must have a constant term");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) crc <= '0;
      else if (clr) crc <= '0;
      else if (upd) crc <= {crc[W-2:0], 1'b0} ^ ((crc[W-1] ^ din) ? POLY : '0);
      else if (shl) crc <= {crc[W-2:0], 1'b0};
   end
endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
   import sdcmd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall_stb,
   input  logic             load,
   input  logic [IDX_W-1:0] idx,
   input  logic [ARG_W-1:0] arg,
   output logic             cmd_out,
   output logic             cmd_oe,
   output logic             done_p
);
   localparam int BODY = CMD_BITS - CRC_W - 1;
   localparam int CNT_W = $clog2(CMD_BITS + 1);
   localparam logic [CNT_W-1:0] N_BODY = CNT_W'(BODY);
   localparam logic [CNT_W-1:0] N_STOP = CNT_W'(CMD_BITS - 1);
   localparam logic [CNT_W-1:0] N_END = CNT_W'(CMD_BITS);

   logic             active;
   logic [CNT_W-1:0] cnt;
   logic [BODY-1:0]  sh;
   logic [CRC_W-1:0] crc;
   logic             step;

   assign step = active && fall_stb;

   sdcmd_crc7 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(load),
      .upd(step && (cnt < N_BODY)),
      .shl(step && (cnt >= N_BODY) && (cnt < N_STOP)),
      .din(sh[BODY-1]), .crc(crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         cnt     <= '0;
         sh      <= '0;
         cmd_out <= 1'b1;
         cmd_oe  <= 1'b0;
         done_p  <= 1'b0;
      end else begin
         done_p <= 1'b0;
         if (load) begin
            active <= 1'b1;
            cnt    <= '0;
            sh     <= {2'b01, idx, arg};
         end else if (step) begin
            if (cnt == N_END) begin
               active  <= 1'b0;
               cmd_oe  <= 1'b0;
               cmd_out <= 1'b1;
               done_p  <= 1'b1;
            end else begin
               cmd_oe <= 1'b1;
               cnt    <= cnt + 1'b1;
               if (cnt < N_BODY) begin
                  cmd_out <= sh[BODY-1];
                  sh      <= {sh[BODY-2:0], 1'b0};
               end else if (cnt < N_STOP) begin
                  cmd_out <= crc[CRC_W-1];
               end else begin
                  cmd_out <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
   import sdcmd_pkg::*;
#(
   parameter int TMO_W = 16,
   parameter int TURN_CYC = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rise_stb,
   input  logic                go,
   input  logic                long_sel,
   input  logic [TMO_W-1:0]    tmo_lim,
   input  logic                cmd_in,
   output logic [RSP_LONG-1:0] rsp,
   output evt_t                evt
);
   localparam int TC_W = $clog2(TURN_CYC + 1);
   localparam int BC_W = $clog2(RSP_LONG + 1);
   localparam logic [TC_W-1:0] TURN_LAST = TC_W'(TURN_CYC - 1);
   localparam logic [BC_W-1:0] S_LAST = BC_W'(RSP_SHORT - 1);
   localparam logic [BC_W-1:0] L_LAST = BC_W'(RSP_LONG - 1);
   localparam logic [BC_W-1:0] S_COV_END = BC_W'(RSP_SHORT - CRC_W - 2);
   localparam logic [BC_W-1:0] L_COV_BEG = BC_W'(RSP_LONG - 128);
   localparam logic [BC_W-1:0] L_COV_END = BC_W'(RSP_LONG - CRC_W - 2);

   if (TURN_CYC < 1) begin : g_bad_turn
      $error("sdcmd_rx: TURN_CYC must be at least 1");
   end

   typedef enum logic [1:0] {IDLE, TURN, WAIT, RECV} st_e;
   st_e                 st;
   logic [TC_W-1:0]     tcnt;
   logic [TMO_W-1:0]    wcnt;
   logic [TMO_W:0]      wnext;
   logic [BC_W-1:0]     bcnt;
   logic [BC_W-1:0]     last_idx;
   logic                in_cov;
   logic [RSP_LONG-1:0] full;
   logic [CRC_W-1:0]    crc;
   logic                dir_bit, frm_bad, crc_bad;

   assign wnext    = {1'b0, wcnt} + 1'b1;
   assign last_idx = long_sel ? L_LAST : S_LAST;
   assign in_cov   = long_sel ? (bcnt >= L_COV_BEG && bcnt <= L_COV_END)
                              : (bcnt <= S_COV_END);
   assign full     = {rsp[RSP_LONG-2:0], cmd_in};
   assign dir_bit  = long_sel ? full[RSP_LONG-2] : full[RSP_SHORT-2];
   assign frm_bad  = dir_bit || !cmd_in;
   assign crc_bad  = (full[CRC_W:1] != crc);

   sdcmd_crc7 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(go),
      .upd(st == RECV && rise_stb && in_cov),
      .shl(1'b0), .din(cmd_in), .crc(crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= IDLE;
         tcnt <= '0;
         wcnt <= '0;
         bcnt <= '0;
         rsp  <= '0;
         evt  <= '0;
      end else begin
         evt <= '0;
         case (st)
            IDLE: if (go) begin
               st   <= TURN;
               tcnt <= '0;
               rsp  <= '0;
            end
            TURN: if (rise_stb) begin
               if (tcnt == TURN_LAST) begin
                  st   <= WAIT;
                  wcnt <= '0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            WAIT: if (rise_stb) begin
               if (!cmd_in) begin
                  st   <= RECV;
                  bcnt <= BC_W'(1);
                  rsp  <= {rsp[RSP_LONG-2:0], 1'b0};
               end else if (wnext >= {1'b0, tmo_lim}) begin
                  st      <= IDLE;
                  evt.tmo <= 1'b1;
               end else begin
                  wcnt <= wnext[TMO_W-1:0];
               end
            end
            RECV: if (rise_stb) begin
               rsp <= full;
               if (bcnt == last_idx) begin
                  st       <= IDLE;
                  evt.done <= !frm_bad && !crc_bad;
                  evt.crc  <= crc_bad;
                  evt.frm  <= frm_bad;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            default: st <= IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdcmd_irq.sv
module sdcmd_irq #(
   parameter int N = 4,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] sts,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else if (set[i]) q <= 1'b1;
         else if (clr[i]) q <= 1'b0;
      end
      assign sts[i] = q;
   end

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else irq <= |(sts & en);
      end
   end else begin : g_irq_comb
      assign irq = |(sts & en);
   end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
   import sdcmd_pkg::*;
#(
   parameter int TMO_W = 16,
   parameter int TURN_CYC = 2,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                card_fall,
   input  logic                card_rise,
   input  logic                start,
   input  logic [IDX_W-1:0]    cmd_idx,
   input  logic [ARG_W-1:0]    cmd_arg,
   input  logic [1:0]          rsp_kind,
   input  logic [TMO_W-1:0]    tmo_lim,
   input  logic [NSTS-1:0]     sts_clr,
   input  logic [NSTS-1:0]     irq_en,
   output logic                cmd_out,
   output logic                cmd_oe,
   input  logic                cmd_in,
   output logic                busy,
   output logic [NSTS-1:0]     sts,
   output logic                irq,
   output logic [RSP_LONG-1:0] rsp_bits
);
   if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo
      $error("sdcmd_engine: TMO_W out of range");
   end

   rsp_kind_e       kind_q;
   logic            accept, tx_done, no_rsp_done, rx_go;
   evt_t            rx_evt;
   logic [NSTS-1:0] set_vec;

   assign accept      = start && !busy;
   assign no_rsp_done = tx_done && (kind_q == KIND_NONE);
   assign rx_go       = tx_done && (kind_q != KIND_NONE);
   assign set_vec     = rx_evt | {{(NSTS-1){1'b0}}, no_rsp_done};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         kind_q <= KIND_NONE;
      end else if (accept) begin
         busy   <= 1'b1;
         kind_q <= rsp_kind_e'(rsp_kind);
      end else if (no_rsp_done || (|rx_evt)) begin
         busy <= 1'b0;
      end
   end

   sdcmd_tx u_tx (
      .clk(clk), .rst_n(rst_n), .fall_stb(card_fall), .load(accept),
      .idx(cmd_idx), .arg(cmd_arg),
      .cmd_out(cmd_out), .cmd_oe(cmd_oe), .done_p(tx_done)
   );

   sdcmd_rx #(.TMO_W(TMO_W), .TURN_CYC(TURN_CYC)) u_rx (
      .clk(clk), .rst_n(rst_n), .rise_stb(card_rise), .go(rx_go),
      .long_sel(kind_q == KIND_LONG), .tmo_lim(tmo_lim), .cmd_in(cmd_in),
      .rsp(rsp_bits), .evt(rx_evt)
   );

   sdcmd_irq #(.N(NSTS), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(sts_clr),
      .en(irq_en), .sts(sts), .irq(irq)
   );
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_oe,
   input logic       cmd_out,
   input logic       busy,
   input logic [3:0] sts,
   input logic [3:0] sts_clr
);
   // R4
   oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oe |-> busy);
   // R1
   first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_oe) |-> !cmd_out);
   // R4
   release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_oe) |-> cmd_out);
   // R12
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (~sts & $past(sts) & ~$past(sts_clr)) == 4'b0000);
   // R7
   tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[1]) |-> !$rose(sts[0]));
   // R5
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[0]) |-> (!busy && $past(busy)));
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_oe(cmd_oe), .cmd_out(cmd_out),
   .busy(busy), .sts(sts), .sts_clr(sts_clr)
);

// File: tb/sdcmd_engine_bench.sv
module sdcmd_engine_bench;
   localparam int TMO_W = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic card_fall = 1'b0, card_rise = 1'b0, start = 1'b0, cmd_in = 1'b1;
   logic [5:0] cmd_idx = '0;
   logic [31:0] cmd_arg = '0;
   logic [1:0] rsp_kind = '0;
   logic [TMO_W-1:0] tmo_lim = '0;
   logic [3:0] sts_clr = '0, irq_en = '0;
   logic cmd_out, cmd_oe, busy, irq;
   logic [3:0] sts;
   logic [135:0] rsp_bits;
   int nchk = 0, nerr = 0;
   bit finished = 0;

   sdcmd_engine #(.TMO_W(TMO_W), .TURN_CYC(2), .IRQ_REG(1'b1)) u_sdcmd_engine (
      .clk(clk), .rst_n(rst_n), .card_fall(card_fall), .card_rise(card_rise),
      .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_kind(rsp_kind),
      .tmo_lim(tmo_lim), .sts_clr(sts_clr), .irq_en(irq_en), .cmd_out(cmd_out),
      .cmd_oe(cmd_oe), .cmd_in(cmd_in), .busy(busy), .sts(sts), .irq(irq),
      .rsp_bits(rsp_bits)
   );

   always #10 clk = ~clk;

   initial begin
      int ph = 3;
      forever begin
         @(negedge clk);
         ph = (ph + 1) % 4;
         card_fall = (ph == 0);
         card_rise = (ph == 2);
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: act=running exp=finished");
      summary();
   end

   task automatic chk(input bit ok, input string req, input logic [135:0] act,
                      input logic [135:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] crc7(input logic [135:0] v, input int n);
      logic [6:0] c = '0;
      for (int i = n - 1; i >= 0; i--) begin
         logic fb = c[6] ^ v[i];
         c = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

   function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] a);
      logic [39:0] body = {2'b00, idx, a};
      return {88'h0, body, crc7({96'h0, body}, 40), 1'b1};
   endfunction

   function automatic logic [135:0] mk_long(input logic [119:0] p);
      return {8'h3F, p, crc7({16'h0, p}, 120), 1'b1};
   endfunction

   task automatic wait_fall();
      do begin @(posedge clk); #1; end while (!card_fall);
   endtask

   task automatic wait_rise();
      do begin @(posedge clk); #1; end while (!card_rise);
   endtask

   task automatic clr_all();
      @(posedge clk); #1 sts_clr = 4'hF;
      @(posedge clk); #1 sts_clr = 4'h0;
      repeat (2) @(posedge clk); #1;
   endtask

   task automatic issue(input logic [5:0] idx, input logic [31:0] a, input logic [1:0] k);
      cmd_idx = idx; cmd_arg = a; rsp_kind = k;
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
   endtask

   task automatic capture(output logic [47:0] fr, input bit poke);
      int n = 0;
      bit oe_ok = 1;
      fr = '0;
      do begin wait_rise(); n++; end while (!cmd_oe && n < 12);
      for (int i = 0; i < 48; i++) begin
         if (i > 0) wait_rise();
         if (!cmd_oe) oe_ok = 0;
         fr = {fr[46:0], cmd_out};
         if (poke && i == 10) begin
            cmd_idx = 6'h3F; cmd_arg = 32'hFFFF_FFFF; start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
         end
      end
      chk(oe_ok, "R4 drive enable held for 48 bits", 136'(oe_ok), 136'(1));
      wait_fall();
      chk(!cmd_oe && cmd_out, "R4 release high", {cmd_oe, cmd_out}, 136'b01);
   endtask

   task automatic card_reply(input logic [135:0] v, input int n, input int d, input bit glitch);
      for (int k = 1; k <= d; k++) begin
         wait_fall();
         if (glitch && k == 1) cmd_in = 1'b0;
         if (glitch && k == 2) cmd_in = 1'b1;
      end
      for (int i = 0; i < n; i++) begin
         if (i > 0) wait_fall();
         cmd_in = v[n-1-i];
      end
      wait_fall();
      cmd_in = 1'b1;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 5000) begin @(posedge clk); #1; n++; end
      repeat (3) @(posedge clk); #1;
   endtask

   task automatic t_reset();
      chk(sts == 4'h0 && !irq && !busy, "R12 reset status", {sts, irq, busy}, 136'h0);
      chk(!cmd_oe && cmd_out, "R4 reset line", {cmd_oe, cmd_out}, 136'b01);
   endtask

   task automatic t_none();
      logic [47:0] fr;
      clr_all(); irq_en = 4'h0;
      issue(6'd0, 32'h0, 2'b00);
      capture(fr, 0);
      chk(fr == 48'h40_0000_0000_95, "R1 R3 frame of index 0", fr, 48'h40_0000_0000_95);
      wait_idle();
      chk(sts == 4'b0001 && !busy, "R5 no-response done", {sts, busy}, 136'b00010);
      chk(!irq, "R13 masked irq low", irq, 0);
      irq_en = 4'b0001; repeat (2) @(posedge clk); #1;
      chk(irq, "R13 enabled irq high", irq, 1);
      sts_clr = 4'b0001; @(posedge clk); #1 sts_clr = 0; repeat (2) @(posedge clk); #1;
      chk(sts == 4'h0 && !irq, "R12 clear done bit", {sts, irq}, 136'h0);
      irq_en = 4'h0;
   endtask

   task automatic t_short();
      logic [47:0] fr;
      logic [135:0] v = mk_short(6'd8, 32'h0000_01AA);
      clr_all(); tmo_lim = 6'd10;
      issue(6'd8, 32'h0000_01AA, 2'b01);
      capture(fr, 0);
      chk(fr == 48'h48_0000_01AA_87, "R2 R3 frame of index 8", fr, 48'h48_0000_01AA_87);
      card_reply(v, 48, 2, 0);
      wait_idle();
      chk(sts == 4'b0001, "R8 short response done", sts, 4'b0001);
      chk(rsp_bits == v, "R8 short response captured", rsp_bits, v);
   endtask

   task automatic t_long();
      logic [47:0] fr;
      logic [119:0] p = 120'hA5C3_0F1E_2D3C_4B5A_6978_8796_A5B4_C3;
      logic [135:0] v = mk_long(p);
      clr_all(); tmo_lim = 6'd10;
      issue(6'd17, 32'h0, 2'b10);
      capture(fr, 0);
      chk(fr == 48'h51_0000_0000_55, "R2 R3 frame of index 17", fr, 48'h51_0000_0000_55);
      card_reply(v, 136, 3, 0);
      wait_idle();
      chk(sts == 4'b0001, "R9 long response done", sts, 4'b0001);
      chk(rsp_bits[127:8] == p, "R9 long payload captured", rsp_bits[127:8], p);
   endtask

   task automatic t_tmo_edge();
      logic [47:0] fr;
      logic [135:0] v = mk_short(6'd13, 32'h1234_5678);
      clr_all(); tmo_lim = 6'd4;
      issue(6'd13, 32'h1234_5678, 2'b11);
      capture(fr, 0);
      card_reply(v, 48, 5, 0);
      wait_idle();
      chk(sts == 4'b0001, "R7 R8 start one sample before limit", sts, 4'b0001);
      clr_all();
      issue(6'd13, 32'h1234_5678, 2'b11);
      capture(fr, 0);
      card_reply(v, 48, 6, 0);
      wait_idle();
      chk(sts == 4'b0010, "R7 start at limit times out", sts, 4'b0010);
   endtask

   task automatic t_noresp();
      logic [47:0] fr;
      clr_all(); tmo_lim = 6'd3;
      issue(6'd55, 32'h0, 2'b01);
      capture(fr, 0);
      wait_idle();
      chk(sts == 4'b0010 && !busy, "R7 silent card times out", {sts, busy}, 136'b00100);
   endtask

   task automatic t_crc();
      logic [47:0] fr;
      logic [135:0] v = mk_short(6'd7, 32'hDEAD_BEEF) ^ 136'h2;
      clr_all(); tmo_lim = 6'd10;
      issue(6'd7, 32'h0, 2'b01);
      capture(fr, 0);
      card_reply(v, 48, 2, 0);
      wait_idle();
      chk(sts == 4'b0100, "R10 bad CRC flagged", sts, 4'b0100);
   endtask

   task automatic t_frame();
      logic [47:0] fr;
      logic [135:0] v = mk_short(6'd9, 32'h0F0F_0F0F) & ~136'h1;
      logic [39:0] body = {2'b01, 6'd9, 32'h0F0F_0F0F};
      logic [135:0] w = {88'h0, body, crc7({96'h0, body}, 40), 1'b1};
      clr_all(); tmo_lim = 6'd10;
      issue(6'd9, 32'h0, 2'b01);
      capture(fr, 0);
      card_reply(v, 48, 2, 0);
      wait_idle();
      chk(sts == 4'b1000, "R11 stop bit zero flagged", sts, 4'b1000);
      clr_all();
      issue(6'd9, 32'h0, 2'b01);
      capture(fr, 0);
      card_reply(w, 48, 2, 0);
      wait_idle();
      chk(sts == 4'b1000, "R11 direction bit one flagged", sts, 4'b1000);
   endtask

   task automatic t_turn();
      logic [47:0] fr;
      logic [135:0] v = mk_short(6'd3, 32'hCAFE_0001);
      clr_all(); tmo_lim = 6'd2;
      issue(6'd3, 32'h0, 2'b01);
      capture(fr, 0);
      card_reply(v, 48, 3, 1);
      wait_idle();
      chk(sts == 4'b0001, "R6 low during turnaround ignored", sts, 4'b0001);
      chk(rsp_bits == v, "R6 response aligned after turnaround", rsp_bits, v);
   endtask

   task automatic t_busy();
      logic [47:0] fr;
      clr_all();
      issue(6'd8, 32'h0000_01AA, 2'b00);
      capture(fr, 1);
      chk(fr == 48'h48_0000_01AA_87, "R14 start while busy ignored", fr, 48'h48_0000_01AA_87);
      wait_idle();
      chk(sts == 4'b0001 && !busy, "R14 single command completed", {sts, busy}, 136'b00010);
   endtask

   task automatic t_w1c_mask();
      logic [47:0] fr;
      logic [135:0] v = mk_short(6'd1, 32'h1) ^ 136'h2;
      clr_all(); tmo_lim = 6'd3; irq_en = 4'h0;
      issue(6'd1, 32'h0, 2'b01);
      capture(fr, 0);
      wait_idle();
      tmo_lim = 6'd10;
      issue(6'd1, 32'h0, 2'b01);
      capture(fr, 0);
      card_reply(v, 48, 2, 0);
      wait_idle();
      chk(sts == 4'b0110, "R12 events accumulate", sts, 4'b0110);
      sts_clr = 4'b0010; @(posedge clk); #1 sts_clr = 0; repeat (2) @(posedge clk); #1;
      chk(sts == 4'b0100, "R12 partial clear", sts, 4'b0100);
      irq_en = 4'b0010; repeat (2) @(posedge clk); #1;
      chk(!irq, "R13 cleared source masked out", irq, 0);
      irq_en = 4'b0100; repeat (2) @(posedge clk); #1;
      chk(irq, "R13 CRC source raises irq", irq, 1);
      irq_en = 4'h0;
   endtask

   initial begin
      repeat (3) @(posedge clk); #1 rst_n = 1'b1;
      repeat (2) @(posedge clk); #1;
      t_reset();
      t_none();
      t_short();
      t_long();
      t_tmo_edge();
      t_noresp();
      t_crc();
      t_frame();
      t_turn();
      t_busy();
      t_w1c_mask();
      summary();
   end
endmodule